// File: doc/BRIEF.md
# System Control and Timebase Register Block

This block is a peripheral on a simple 32-bit memory-mapped bus. Software uses it to drive board LEDs and three active-low SPI chip selects, to set four debug-permission outputs, and to read two push buttons and eight switches. The button and switch inputs are synchronised to the system clock.

It also keeps time. Two free-running 32-bit counters advance at 1 Hz and 100 Hz. They are paced by dividers whose ratios come from the `CLK_HZ` parameter. A third 32-bit counter advances on every clock in which a reloadable 32-bit down-counting prescaler sits at zero. Software can therefore count cycles in steps of `reload + 1` clocks. All three counters can be written to preset them.

The bus is single-cycle. A write with `bus_valid` and `bus_write` high takes effect at that clock edge. A read with `bus_valid` high and `bus_write` low captures the register value, as it stood before that edge, into `bus_rdata`. `bus_rdata` then holds until the next read.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the LED field, the debug field, the prescaler reload and count, and all three counters are zero. The chip-select field is 3'b111, so all selects are inactive.
- R2: Word offset 0x000 holds the LED state in bits [9:0], which drive `led_o`. A read returns these bits with bits [31:10] zero.
- R3: Offset 0x004 holds the debug permissions. Bit 0 drives `dbg_inv_o`, bit 1 `dbg_noninv_o`, bit 2 `dbg_sec_inv_o` and bit 3 `dbg_sec_noninv_o`. A read returns bits [3:0] with the upper bits zero.
- R4: Offset 0x008 reads the buttons in bits [1:0] and offset 0x028 reads the switches in bits [7:0]. Each passes through two synchronising flops, so a change is readable by the third clock edge after it. Writes to either offset change nothing.
- R5: Offset 0x04C holds the chip selects. Bit 0 drives `spi_cs_n_o[0]` (ADC), bit 1 drives `spi_cs_n_o[1]` (shield 0) and bit 2 drives `spi_cs_n_o[2]` (shield 1).
- R6: Offset 0x01C holds the prescaler reload value. Offset 0x020 reads the live prescaler count, which is read-only. On each clock the count decrements if it is nonzero, and is loaded from the reload value if it is zero.
- R7: The cycle counter at 0x018 increments on every clock in which the prescaler count is zero. With reload R, it therefore advances once every R+1 clocks, and every clock when R is 0. A write presets it and takes priority over the increment.
- R8: The counter at 0x010 increments once per `CLK_HZ` clocks, and the counter at 0x014 once per `CLK_HZ/100` clocks. Both are writable presets, and a write takes priority over the increment.
- R9: Unmapped and misaligned addresses, including 0x00C and 0x024, read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| btn_i | input | 2 | Push buttons (asynchronous) |
| sw_i | input | 8 | Switches (asynchronous) |
| led_o | output | 10 | LED drive |
| dbg_inv_o | output | 1 | Invasive debug enable |
| dbg_noninv_o | output | 1 | Non-invasive debug enable |
| dbg_sec_inv_o | output | 1 | Secure invasive debug enable |
| dbg_sec_noninv_o | output | 1 | Secure non-invasive debug enable |
| spi_cs_n_o | output | 3 | Active-low chip selects |

## Verification
The prescaled counter is tried with three reload values:
- A reload of 4 tells a correct period of R+1 clocks from an off-by-one period of R or R+2.
- A reload of 0 shows that the counter then advances every clock.
- Back-to-back reads of the live count show whether the count decrements or reloads.

The two time-of-day counters are sampled exactly one divider period apart. An error in either division ratio changes the difference between the two samples. Distinct bit patterns written to the LED, debug and chip-select fields expose any swapped or misplaced bit. All-ones writes to read-only and unmapped offsets show whether those writes really have no effect.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LED_W  = 10;
    localparam int DBG_W  = 4;
    localparam int BTN_W  = 2;
    localparam int SW_W   = 8;
    localparam int CS_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_LED   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_DBG   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_BTN   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_SEC   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_CSEC  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_CYC   = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_RLD   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_PSC   = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_SW    = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_CS    = 12'h04C;

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [DBG_W-1:0]  dbg;
        logic [CS_W-1:0]   cs_n;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] csec;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d, sync_q, sync_d;

    always_comb begin
        meta_d = async_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/sysctl_tick_div.sv
module sysctl_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q, cnt_d;
            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign tick_o = (cnt_q == LAST);

            // R8: the enable lasts a single cycle
            a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/sysctl_prescale.sv
module sysctl_prescale #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             cyc_we_i,
    input  logic [CNT_W-1:0] cyc_wdata_i,
    output logic [CNT_W-1:0] psc_o,
    output logic [CNT_W-1:0] cyc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] psc;
        logic [CNT_W-1:0] cyc;
    } psc_state_t;

    psc_state_t st_q, st_d;
    logic at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.psc == '0);
        if (at_zero) st_d.psc = reload_i;
        else         st_d.psc = st_q.psc - 1'b1;
        if (cyc_we_i)     st_d.cyc = cyc_wdata_i;
        else if (at_zero) st_d.cyc = st_q.cyc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psc_o = st_q.psc;
    assign cyc_o = st_q.cyc;

    // R6: a nonzero count steps down by one
    a_r6_psc_down: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_o != '0) |=> (psc_o == $past(psc_o) - 1'b1));
    // R6: a zero count reloads
    a_r6_psc_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_o == '0) |=> (psc_o == $past(reload_i)));
    // R7: counter advances on a zero count when not written
    a_r7_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_o == '0 && !cyc_we_i) |=> (cyc_o == $past(cyc_o) + 1'b1));
    // R7: counter holds on a nonzero count when not written
    a_r7_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_o != '0 && !cyc_we_i) |=> $stable(cyc_o));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  btn_i,
    input  logic [7:0]  sw_i,
    output logic [9:0]  led_o,
    output logic        dbg_inv_o,
    output logic        dbg_noninv_o,
    output logic        dbg_sec_inv_o,
    output logic        dbg_sec_noninv_o,
    output logic [2:0]  spi_cs_n_o
);
    import sysctl_pkg::*;

    localparam int DIV_SEC  = CLK_HZ;
    localparam int DIV_CSEC = (CLK_HZ / 100 > 0) ? CLK_HZ / 100 : 1;

    regs_t regs_q, regs_d;

    logic              tick_sec, tick_csec;
    logic [BTN_W-1:0]  btn_s;
    logic [SW_W-1:0]   sw_s;
    logic [DATA_W-1:0] psc_val, cyc_val;
    logic              aligned, wr, rd;
    logic              wr_led, wr_dbg, wr_cs, wr_sec, wr_csec, wr_cyc, wr_rld;
    logic [DATA_W-1:0] rd_val;

    sysctl_sync #(.W(BTN_W)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .async_i(btn_i), .sync_o(btn_s));
    sysctl_sync #(.W(SW_W)) u_sw_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sw_i), .sync_o(sw_s));

    sysctl_tick_div #(.DIV(DIV_SEC)) u_div_sec (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_sec));
    sysctl_tick_div #(.DIV(DIV_CSEC)) u_div_csec (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_csec));

    sysctl_prescale #(.CNT_W(DATA_W)) u_prescale (
        .clk(clk), .rst_n(rst_n),
        .reload_i(regs_q.reload),
        .cyc_we_i(wr_cyc), .cyc_wdata_i(bus_wdata),
        .psc_o(psc_val), .cyc_o(cyc_val));

    // address decode
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        wr      = bus_valid && bus_write && aligned;
        rd      = bus_valid && !bus_write;
        wr_led  = wr && (bus_addr == OFF_LED);
        wr_dbg  = wr && (bus_addr == OFF_DBG);
        wr_cs   = wr && (bus_addr == OFF_CS);
        wr_sec  = wr && (bus_addr == OFF_SEC);
        wr_csec = wr && (bus_addr == OFF_CSEC);
        wr_cyc  = wr && (bus_addr == OFF_CYC);
        wr_rld  = wr && (bus_addr == OFF_RLD);
        rd_val  = '0;
        if (aligned) begin
            case (bus_addr)
                OFF_LED:  rd_val = DATA_W'(regs_q.led);
                OFF_DBG:  rd_val = DATA_W'(regs_q.dbg);
                OFF_BTN:  rd_val = DATA_W'(btn_s);
                OFF_SEC:  rd_val = regs_q.sec;
                OFF_CSEC: rd_val = regs_q.csec;
                OFF_CYC:  rd_val = cyc_val;
                OFF_RLD:  rd_val = regs_q.reload;
                OFF_PSC:  rd_val = psc_val;
                OFF_SW:   rd_val = DATA_W'(sw_s);
                OFF_CS:   rd_val = DATA_W'(regs_q.cs_n);
                default:  rd_val = '0;
            endcase
        end
    end

    // next-state
    always_comb begin
        regs_d = regs_q;
        if (wr_led) regs_d.led    = bus_wdata[LED_W-1:0];
        if (wr_dbg) regs_d.dbg    = bus_wdata[DBG_W-1:0];
        if (wr_cs)  regs_d.cs_n   = bus_wdata[CS_W-1:0];
        if (wr_rld) regs_d.reload = bus_wdata;
        if (wr_sec)        regs_d.sec = bus_wdata;
        else if (tick_sec) regs_d.sec = regs_q.sec + 1'b1;
        if (wr_csec)        regs_d.csec = bus_wdata;
        else if (tick_csec) regs_d.csec = regs_q.csec + 1'b1;
        if (rd) regs_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.cs_n <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata        = regs_q.rdata;
    assign led_o            = regs_q.led;
    assign dbg_inv_o        = regs_q.dbg[0];
    assign dbg_noninv_o     = regs_q.dbg[1];
    assign dbg_sec_inv_o    = regs_q.dbg[2];
    assign dbg_sec_noninv_o = regs_q.dbg[3];
    assign spi_cs_n_o       = regs_q.cs_n;

    // R8: the seconds counter steps on its tick unless written
    a_r8_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sec && !wr_sec) |=> (regs_q.sec == $past(regs_q.sec) + 1'b1));
    // R8: the hundredths counter holds without a tick or write
    a_r8_csec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_csec && !wr_csec) |=> $stable(regs_q.csec));
    // R9: reserved offset reads zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 12'h00C) |=> (bus_rdata == '0));
    // R2: LED read leaves upper bits zero
    a_r2_led_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == OFF_LED) |=> (bus_rdata[31:LED_W] == '0));
    // R5: chip selects change only through a write
    a_r5_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(spi_cs_n_o));
endmodule

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, chk = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  btn_i = '0;
    logic [7:0]  sw_i = '0;
    logic [9:0]  led_o;
    logic        dbg_inv_o, dbg_noninv_o, dbg_sec_inv_o, dbg_sec_noninv_o;
    logic [2:0]  spi_cs_n_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [11:0] a;
        logic [31:0] e;
        string       tag;
    } item_t;
    item_t sb[$];
    item_t it;

    always #5 clk = ~clk;

    sysctl_regs #(.CLK_HZ(1000)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .btn_i(btn_i), .sw_i(sw_i), .led_o(led_o),
        .dbg_inv_o(dbg_inv_o), .dbg_noninv_o(dbg_noninv_o),
        .dbg_sec_inv_o(dbg_sec_inv_o), .dbg_sec_noninv_o(dbg_sec_noninv_o),
        .spi_cs_n_o(spi_cs_n_o));

    // monitor: pops expected items as read data appears
    always @(posedge clk) begin
        if (bus_valid && !bus_write && chk) begin
            #1;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
            end else begin
                it = sb.pop_front();
                n_cmp++;
                if (bus_rdata !== it.e) begin
                    n_bad++;
                    $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.a, bus_rdata, it.e);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; chk = 0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t x;
        x.a = a; x.e = e; x.tag = tag;
        sb.push_back(x);
        bus_valid = 1; bus_write = 0; bus_addr = a; chk = 1;
        @(negedge clk);
        bus_valid = 0; chk = 0;
    endtask

    task automatic rd_get(input logic [11:0] a, output logic [31:0] v);
        bus_valid = 1; bus_write = 0; bus_addr = a; chk = 0;
        @(posedge clk);
        #1 v = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs outputs", {29'd0, spi_cs_n_o}, 32'h7);
        check("R1 led outputs", {22'd0, led_o}, 32'h0);
        check("R1 dbg outputs", {28'd0, dbg_sec_noninv_o, dbg_sec_inv_o, dbg_noninv_o, dbg_inv_o}, 32'h0);
        rd_chk(12'h04C, 32'h7, "R1 cs reg");
        rd_chk(12'h01C, 32'h0, "R1 reload reg");
        rd_chk(12'h020, 32'h0, "R1 prescale count");

        // R2 LEDs
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h3FF, "R2 led width");
        wr(12'h000, 32'h0000_0215);
        check("R2 led pins", {22'd0, led_o}, 32'h215);

        // R3 debug bit order
        wr(12'h004, 32'hFFFF_FFF5);
        check("R3 dbg pins", {28'd0, dbg_sec_noninv_o, dbg_sec_inv_o, dbg_noninv_o, dbg_inv_o}, 32'h5);
        rd_chk(12'h004, 32'h5, "R3 dbg reg");
        wr(12'h004, 32'hA);
        check("R3 dbg pins alt", {28'd0, dbg_sec_noninv_o, dbg_sec_inv_o, dbg_noninv_o, dbg_inv_o}, 32'hA);

        // R5 chip selects
        wr(12'h04C, 32'h0000_0006);
        check("R5 cs pins", {29'd0, spi_cs_n_o}, 32'h6);
        wr(12'h04C, 32'hFFFF_FFF9);
        rd_chk(12'h04C, 32'h1, "R5 cs reg");
        check("R5 cs pins alt", {29'd0, spi_cs_n_o}, 32'h1);

        // R4 inputs through synchronisers
        btn_i = 2'b10; sw_i = 8'hA5;
        idle(3);
        rd_chk(12'h008, 32'h2, "R4 buttons");
        rd_chk(12'h028, 32'hA5, "R4 switches");
        wr(12'h028, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        rd_chk(12'h028, 32'hA5, "R4 switch write ignored");
        rd_chk(12'h008, 32'h2, "R4 button write ignored");

        // R9 unmapped
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        rd_chk(12'h00C, 32'h0, "R9 gap 00C");
        rd_chk(12'h024, 32'h0, "R9 gap 024");
        rd_chk(12'h100, 32'h0, "R9 far offset");
        rd_chk(12'h002, 32'h0, "R9 misaligned");
        wr(12'h001, 32'hFFFF_FFFF);
        rd_chk(12'h000, 32'h215, "R9 misaligned write ignored");

        // R7 reload 0: every clock
        wr(12'h020, 32'h0000_FFFF);
        rd_chk(12'h020, 32'h0, "R6 count read-only");
        wr(12'h018, 32'd100);
        rd_chk(12'h018, 32'd100, "R7 preset");
        rd_get(12'h018, a);
        idle(9);
        rd_get(12'h018, b);
        check("R7 reload 0 rate", b - a, 32'd10);

        // R6/R7 reload 4
        wr(12'h01C, 32'd4);
        rd_chk(12'h01C, 32'd4, "R6 reload reg");
        idle(20);
        rd_get(12'h018, a);
        idle(24);
        rd_get(12'h018, b);
        check("R7 reload 4 rate", b - a, 32'd5);
        rd_get(12'h020, a);
        rd_get(12'h020, b);
        check("R6 count step", b, (a == 0) ? 32'd4 : a - 1);
        rd_get(12'h020, a);
        check("R6 count step 2", a, (b == 0) ? 32'd4 : b - 1);

        // R8 time counters (CLK_HZ = 1000)
        rd_get(12'h010, a);
        idle(999);
        rd_get(12'h010, b);
        check("R8 seconds rate", b - a, 32'd1);
        rd_get(12'h014, a);
        idle(999);
        rd_get(12'h014, b);
        check("R8 hundredths rate", b - a, 32'd100);
        wr(12'h010, 32'h1234_0000);
        rd_chk(12'h010, 32'h1234_0000, "R8 seconds preset");
        wr(12'h014, 32'h0000_0777);
        rd_chk(12'h014, 32'h0000_0777, "R8 hundredths preset");

        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule